// File: doc/BRIEF.md
# Processor Status and Control Register

This block is the run-control and reset-cause register of a small 8-bit microcontroller core. Firmware reads and writes it as a single byte. It decides whether the core may run, and it records why the last reset happened. The core receives a run enable that drops on a halt instruction, after one instruction in single-step mode, or while the device sits in low-power suspend.

A suspend request is accepted only when no interrupt is pending and the bus is quiet. Once in suspend, the device leaves it when either of those conditions appears, and the core continues at the following instruction. The block also watches the raw USB D+ and D− samples. When both lines stay low for longer than a configurable time (8 µs by default), it raises a one-cycle bus-reset interrupt and sets a sticky flag. This event does not reset the core. The block is sized from the system clock frequency in kHz.

Top module: `cpu_stat_ctrl`

## Requirements
- R1: While `por_rst` is high, and on the first cycle after it falls, `rd_data` reads 0x11 (run flag at bit 0, power-on flag at bit 4), `core_run` is 1 and `suspend` is 0, given `irq_pending` and `int_enable` low.
- R2: A `wdt_rst` cycle (with `por_rst` low) loads 0x41 (run flag at bit 0, watchdog flag at bit 6), sets `core_run` to 1 and clears suspend and single-step.
- R3: Any of the following clears run flag bit 0 and drops `core_run` on the next cycle: a `halt_op` cycle, or a write with bit 0 equal to 0. While the flag is clear, no write and no `instr_done` sets it again. Only `por_rst` or `wdt_rst` does.
- R4: While single-step (bit 1, written directly) is 1, the first `instr_done` pulse clears run flag bit 0 and drops `core_run`. While bit 1 is 0, `instr_done` has no effect.
- R5: Bit 2 of `rd_data` shows `int_enable` as sampled in the previous cycle. The bit 2 value of a write is ignored.
- R6: A write with bit 3 set, while `irq_pending` and `bus_active` are both low, sets `suspend`, sets bit 3 of `rd_data` and drops `core_run`.
- R7: A write with bit 3 set in a cycle where `irq_pending` or `bus_active` is high is refused: `suspend` and bit 3 stay 0.
- R8: While suspended, a cycle with `irq_pending` or `bus_active` high clears `suspend`, and `core_run` returns to the value of run flag bit 0.
- R9: Writing 0 to bit 4 (power-on), bit 5 (bus reset) or bit 6 (watchdog) clears that flag. Writing 1 leaves it unchanged.
- R10: When D+ and D− (after a `SYNC_STAGES` synchronizer) are both low for more than `CLK_KHZ*SE0_US/1000` consecutive clocks, `bus_reset_irq` pulses exactly once for that episode and bit 5 becomes 1. Either line going high restarts the count. `core_run` is not affected.
- R11: Bit 7 of `rd_data` shows `irq_pending` as sampled in the previous cycle. The bit 7 value of a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| wdt_rst | input | 1 | Watchdog reset request, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| instr_done | input | 1 | Pulse at the last cycle of each instruction |
| halt_op | input | 1 | Halt instruction strobe |
| int_enable | input | 1 | Core interrupt-enable state |
| irq_pending | input | 1 | One or more interrupts pending |
| bus_active | input | 1 | Bus activity seen |
| usb_dp | input | 1 | Raw D+ line sample |
| usb_dm | input | 1 | Raw D− line sample |
| rd_data | output | 8 | Register read value |
| core_run | output | 1 | Run enable to the core |
| suspend | output | 1 | Suspend state |
| bus_reset_irq | output | 1 | One-cycle bus-reset interrupt request |

## Verification
The bench sweeps every write byte under every combination of pending interrupt and bus activity, after both kinds of reset. A design that let a write set a reset-cause flag, change the read-only bits, or accept a suspend while woken conditions are present would show the wrong byte in that sweep. The line-reset detector is run at SE0 lengths from one clock up to past the threshold. This exposes an off-by-one threshold, which would fire one length too early or too late, a repeated pulse within one long episode, and a count that survives a one-clock high glitch. Separate sequences confirm that a halted core cannot be restarted by a write or by instruction completion, and that single-step stops the core after exactly one completion.

// File: rtl/cpu_stat_pkg.sv
package cpu_stat_pkg;

  // Bit order of this struct is the register layout (bit 7 first).
  typedef struct packed {
    logic irq;      // bit 7
    logic wdt;      // bit 6
    logic usbrst;   // bit 5
    logic por;      // bit 4
    logic susp;     // bit 3
    logic imask;    // bit 2
    logic step;     // bit 1
    logic run;      // bit 0
  } stat_t;

  localparam int RUN_B  = 0;
  localparam int STEP_B = 1;
  localparam int SUSP_B = 3;
  localparam int POR_B  = 4;
  localparam int USB_B  = 5;
  localparam int WDT_B  = 6;

  // Reset-cause flags held as {wdt, usbrst, por}.
  typedef logic [2:0] cause_t;
  localparam cause_t CAUSE_POR = 3'b001;
  localparam cause_t CAUSE_WDT = 3'b100;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/se0_detect.sv
module se0_detect #(
  parameter int LIMIT = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic dp,
  input  logic dm,
  output logic evt
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] AT_LIM  = CW'(LIMIT);
  localparam logic [CW-1:0] SAT_VAL = CW'(LIMIT + 1);

  logic          se0;
  logic [CW-1:0] cnt;

  assign se0 = ~dp & ~dm;

  // Counts consecutive SE0 clocks; saturates past the limit so one
  // episode yields one event.
  always_ff @(posedge clk) begin
    if (rst || !se0) begin
      cnt <= '0;
    end else if (cnt != SAT_VAL) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt <= 1'b0;
    else     evt <= se0 && (cnt == AT_LIM);
  end

endmodule

// File: rtl/stat_ctrl_core.sv
module stat_ctrl_core
  import cpu_stat_pkg::*;
(
  input  logic       clk,
  input  logic       por_rst,
  input  logic       wdt_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       instr_done,
  input  logic       halt_op,
  input  logic       int_enable,
  input  logic       irq_pending,
  input  logic       bus_active,
  input  logic       bus_rst_evt,
  output logic [7:0] rd_data,
  output logic       core_run,
  output logic       suspend
);

  logic   run_q, step_q, susp_q, run_out_q;
  logic   imask_q, irq_q;
  cause_t cause_q;

  logic   n_run, n_step, n_susp;
  cause_t n_cause;
  logic   wake;

  assign wake = irq_pending | bus_active;

  always_comb begin
    n_run   = run_q;
    n_step  = step_q;
    n_susp  = susp_q;
    n_cause = cause_q;
    if (susp_q && wake) n_susp = 1'b0;
    if (wr_en) begin
      n_run   = run_q & wr_data[RUN_B];
      n_step  = wr_data[STEP_B];
      n_cause = cause_q & wr_data[WDT_B:POR_B];
      if (wr_data[SUSP_B] && !wake) n_susp = 1'b1;
    end
    if (halt_op) n_run = 1'b0;
    if (step_q && instr_done) n_run = 1'b0;
    if (bus_rst_evt) n_cause[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por_rst) begin
      run_q     <= 1'b1;
      step_q    <= 1'b0;
      susp_q    <= 1'b0;
      cause_q   <= CAUSE_POR;
      run_out_q <= 1'b1;
    end else if (wdt_rst) begin
      run_q     <= 1'b1;
      step_q    <= 1'b0;
      susp_q    <= 1'b0;
      cause_q   <= CAUSE_WDT;
      run_out_q <= 1'b1;
    end else begin
      run_q     <= n_run;
      step_q    <= n_step;
      susp_q    <= n_susp;
      cause_q   <= n_cause;
      run_out_q <= n_run & ~n_susp;
    end
  end

  // Read-only mirrors are sampled every cycle, reset or not.
  always_ff @(posedge clk) begin
    imask_q <= int_enable;
    irq_q   <= irq_pending;
  end

  stat_t view;
  always_comb begin
    view.irq    = irq_q;
    view.wdt    = cause_q[2];
    view.usbrst = cause_q[1];
    view.por    = cause_q[0];
    view.susp   = susp_q;
    view.imask  = imask_q;
    view.step   = step_q;
    view.run    = run_q;
  end

  assign rd_data  = view;
  assign core_run = run_out_q;
  assign suspend  = susp_q;

endmodule

// File: rtl/cpu_stat_ctrl.sv
module cpu_stat_ctrl #(
  parameter int CLK_KHZ     = 12000,
  parameter int SE0_US      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_rst,
  input  logic       wdt_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       instr_done,
  input  logic       halt_op,
  input  logic       int_enable,
  input  logic       irq_pending,
  input  logic       bus_active,
  input  logic       usb_dp,
  input  logic       usb_dm,
  output logic [7:0] rd_data,
  output logic       core_run,
  output logic       suspend,
  output logic       bus_reset_irq
);

  localparam int SE0_LIMIT = CLK_KHZ * SE0_US / 1000;

  logic [1:0] lines_s;
  logic       evt;

  line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (por_rst),
    .d   ({usb_dp, usb_dm}),
    .q   (lines_s)
  );

  se0_detect #(.LIMIT(SE0_LIMIT)) u_se0 (
    .clk (clk),
    .rst (por_rst),
    .dp  (lines_s[1]),
    .dm  (lines_s[0]),
    .evt (evt)
  );

  stat_ctrl_core u_core (
    .clk         (clk),
    .por_rst     (por_rst),
    .wdt_rst     (wdt_rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .instr_done  (instr_done),
    .halt_op     (halt_op),
    .int_enable  (int_enable),
    .irq_pending (irq_pending),
    .bus_active  (bus_active),
    .bus_rst_evt (evt),
    .rd_data     (rd_data),
    .core_run    (core_run),
    .suspend     (suspend)
  );

  assign bus_reset_irq = evt;

endmodule

// File: rtl/cpu_stat_ctrl_chk.sv
module cpu_stat_ctrl_chk (
  input logic       clk,
  input logic       por_rst,
  input logic       wdt_rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       halt_op,
  input logic       int_enable,
  input logic       irq_pending,
  input logic       bus_active,
  input logic [7:0] rd_data,
  input logic       core_run,
  input logic       suspend,
  input logic       bus_reset_irq
);

  assert_wdt_load_R2: assert property (@(posedge clk) disable iff (por_rst)
    wdt_rst |=> (((rd_data & 8'h7B) == 8'h41) && core_run && !suspend));

  assert_halt_stop_R3: assert property (@(posedge clk) disable iff (por_rst)
    (halt_op && !wdt_rst) |=> !core_run);

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (por_rst)
    (!rd_data[0] && !wdt_rst) |=> !rd_data[0]);

  assert_imask_mirror_R5: assert property (@(posedge clk) disable iff (por_rst)
    1'b1 |=> (rd_data[2] == $past(int_enable)));

  assert_susp_refused_R7: assert property (@(posedge clk) disable iff (por_rst)
    $rose(suspend) |-> $past(wr_en && wr_data[3] && !irq_pending && !bus_active));

  assert_busrst_single_R10: assert property (@(posedge clk) disable iff (por_rst)
    bus_reset_irq |=> !bus_reset_irq);

  assert_irq_mirror_R11: assert property (@(posedge clk) disable iff (por_rst)
    1'b1 |=> (rd_data[7] == $past(irq_pending)));

endmodule

bind cpu_stat_ctrl cpu_stat_ctrl_chk u_chk (
  .clk           (clk),
  .por_rst       (por_rst),
  .wdt_rst       (wdt_rst),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .halt_op       (halt_op),
  .int_enable    (int_enable),
  .irq_pending   (irq_pending),
  .bus_active    (bus_active),
  .rd_data       (rd_data),
  .core_run      (core_run),
  .suspend       (suspend),
  .bus_reset_irq (bus_reset_irq)
);

// File: tb/test_cpu_stat_ctrl.sv
`timescale 1ns/1ps
module test_cpu_stat_ctrl;

  localparam int CLK_KHZ = 2000;
  localparam int SE0_US  = 2;
  localparam int LIM     = CLK_KHZ * SE0_US / 1000;

  logic       clk = 1'b0;
  logic       por_rst, wdt_rst, wr_en, instr_done, halt_op;
  logic       int_enable, irq_pending, bus_active, usb_dp, usb_dm;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       core_run, suspend, bus_reset_irq;

  int checks = 0;
  int failures = 0;
  int pulse_total = 0;

  always #2.5 clk = ~clk;

  cpu_stat_ctrl #(.CLK_KHZ(CLK_KHZ), .SE0_US(SE0_US), .SYNC_STAGES(2)) i_cpu_stat_ctrl (
    .clk(clk), .por_rst(por_rst), .wdt_rst(wdt_rst), .wr_en(wr_en), .wr_data(wr_data),
    .instr_done(instr_done), .halt_op(halt_op), .int_enable(int_enable),
    .irq_pending(irq_pending), .bus_active(bus_active), .usb_dp(usb_dp), .usb_dm(usb_dm),
    .rd_data(rd_data), .core_run(core_run), .suspend(suspend), .bus_reset_irq(bus_reset_irq)
  );

  always @(negedge clk) if (bus_reset_irq === 1'b1) pulse_total++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v; cyc(1); wr_en = 1'b0;
  endtask

  task automatic do_por();
    por_rst = 1'b1; cyc(2); por_rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    por_rst = 1'b1; wdt_rst = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    instr_done = 1'b0; halt_op = 1'b0; int_enable = 1'b0;
    irq_pending = 1'b0; bus_active = 1'b0; usb_dp = 1'b1; usb_dm = 1'b0;
    cyc(3);
    chk("R1 during por", {rd_data, core_run, suspend}, {8'h11, 1'b1, 1'b0});
    por_rst = 1'b0; cyc(1);
    chk("R1 after por", {rd_data, core_run, suspend}, {8'h11, 1'b1, 1'b0});

    // R2
    wdt_rst = 1'b1; cyc(1); wdt_rst = 1'b0;
    chk("R2 watchdog load", {rd_data, core_run, suspend}, {8'h41, 1'b1, 1'b0});

    // Sweep every write byte, reset kind and wake combination: R5 R6 R7 R9 R11
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 4; c++) begin
        for (int v = 0; v < 256; v++) begin
          logic [2:0] ef;
          logic       es, ir, ba;
          logic [7:0] vv;
          vv = v[7:0];
          if (r == 0) por_rst = 1'b1; else wdt_rst = 1'b1;
          cyc(1);
          por_rst = 1'b0; wdt_rst = 1'b0;
          ir = c[0]; ba = c[1];
          irq_pending = ir; bus_active = ba; int_enable = ~vv[2];
          wr(vv);
          ef = ((r == 0) ? 3'b001 : 3'b100) & vv[6:4];
          es = vv[3] & ~ir & ~ba;
          chk("R5 R6 R7 R9 R11 write sweep", {rd_data, core_run, suspend},
              {ir, ef, es, ~vv[2], vv[1], vv[0], vv[0] & ~es, es});
        end
      end
    end
    irq_pending = 1'b0; bus_active = 1'b0; int_enable = 1'b0;

    // R3: halt is permanent until reset
    do_por();
    halt_op = 1'b1; cyc(1); halt_op = 1'b0;
    chk("R3 halt", {rd_data, core_run, suspend}, {8'h10, 1'b0, 1'b0});
    wr(8'h11);
    instr_done = 1'b1; cyc(1); instr_done = 1'b0;
    chk("R3 no restart by write", {rd_data, core_run, suspend}, {8'h10, 1'b0, 1'b0});
    wdt_rst = 1'b1; cyc(1); wdt_rst = 1'b0;
    chk("R3 restart by watchdog", {rd_data, core_run}, {8'h41, 1'b1});

    // R4: single step
    do_por();
    instr_done = 1'b1; cyc(3); instr_done = 1'b0;
    chk("R4 no step mode", {rd_data, core_run}, {8'h11, 1'b1});
    wr(8'h13); cyc(2);
    chk("R4 step armed", {rd_data, core_run}, {8'h13, 1'b1});
    instr_done = 1'b1; cyc(1); instr_done = 1'b0;
    chk("R4 step stop", {rd_data, core_run}, {8'h12, 1'b0});

    // R6 R8: suspend and wake
    do_por();
    wr(8'h19); cyc(3);
    chk("R6 suspended", {rd_data, core_run, suspend}, {8'h19, 1'b0, 1'b1});
    irq_pending = 1'b1; cyc(1); irq_pending = 1'b0;
    chk("R8 wake by irq", {rd_data, core_run, suspend}, {8'h91, 1'b1, 1'b0});
    wr(8'h19);
    bus_active = 1'b1; cyc(1); bus_active = 1'b0;
    chk("R8 wake by bus", {rd_data, core_run, suspend}, {8'h11, 1'b1, 1'b0});

    // R10: SE0 length sweep around the threshold
    for (int l = 1; l <= LIM + 3; l++) begin
      int p0;
      logic hit;
      do_por();
      p0 = pulse_total;
      usb_dp = 1'b0; usb_dm = 1'b0;
      cyc(l);
      if (l % 2 == 0) usb_dm = 1'b1; else usb_dp = 1'b1;
      cyc(8);
      usb_dp = 1'b1; usb_dm = 1'b0;
      hit = (l > LIM);
      chk("R10 se0 length", {2'(pulse_total - p0), rd_data[5], core_run, 6'd0},
          {1'b0, hit, hit, 1'b1, 6'd0});
    end

    // R9: clearing the bus-reset flag (still set from the longest run)
    chk("R9 flags before", {rd_data, core_run, suspend}, {8'h31, 1'b1, 1'b0});
    wr(8'h21);
    chk("R9 keep bus flag", {rd_data, core_run, suspend}, {8'h21, 1'b1, 1'b0});
    wr(8'h01);
    chk("R9 clear bus flag", {rd_data, core_run, suspend}, {8'h01, 1'b1, 1'b0});
    wr(8'h71);
    chk("R9 write one ignored", {rd_data, core_run, suspend}, {8'h01, 1'b1, 1'b0});

    // R10: glitch restarts the count, long episode gives one pulse
    begin
      int p0;
      do_por();
      p0 = pulse_total;
      usb_dp = 1'b0; usb_dm = 1'b0; cyc(LIM);
      usb_dp = 1'b1; cyc(1);
      usb_dp = 1'b0; cyc(LIM);
      usb_dp = 1'b1; cyc(8);
      chk("R10 glitch restart", {pulse_total - p0, 2'b0}, {32'd0, 2'b0});
      p0 = pulse_total;
      usb_dp = 1'b0; usb_dm = 1'b0; cyc(3 * LIM);
      usb_dp = 1'b1; cyc(8);
      chk("R10 one pulse per episode", {pulse_total - p0, rd_data[5], core_run},
          {32'd1, 1'b1, 1'b1});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule